// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block holds a small, fully associative set of virtual-to-physical page translations for a 32-bit virtual address space with 4 KB pages. On a lookup, the 20-bit virtual page number is compared with every valid entry at once. The 12-bit page offset passes through untranslated. One cycle after the request, the block reports one of three outcomes: a hit with the physical address, a miss, or a protection fault. A fault means the page is mapped but the entry's rights do not allow the requested kind of access.

The hardware never walks a page table. A miss is a trap for software. The miss handler finds the translation and installs it through a one-cycle install port. The block picks the slot to overwrite from the entries' valid and reference bits, using an approximation of least-recently-used. When an install overwrites a live entry, the eviction port reports that entry's page number and dirty state, so software knows whether the page must be written back.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid and all registered outputs are 0, so every lookup misses until software installs an entry.
- R2: A lookup is presented for one cycle on the request inputs. On a permitted match, the next cycle shows lk_hit=1 and lk_paddr = {entry physical page, request bits [11:0]}.
- R3: A lookup whose page number matches no valid entry gives, in the next cycle, lk_miss=1, lk_hit=0, lk_fault=0 and lk_paddr=0.
- R4: Access codes are 00 read, 01 write, 10 instruction fetch and 11 reserved; the reserved code is never permitted. Rights codes and what they permit:
  - 00 (read-only): read only.
  - 01 (read/write): read and write.
  - 10 (executable): read and fetch.
  - 11: nothing.
  A matching access that is not permitted gives lk_fault=1, lk_hit=0 and lk_paddr=0 in the next cycle.
- R5: At most one of lk_hit, lk_miss and lk_fault is 1 in any cycle. A fault needs a valid matching entry, so a lookup with no match reports only a miss, even with the reserved access code.
- R6: In the cycle after a cycle with no request, lk_hit, lk_miss, lk_fault and lk_paddr are all 0.
- R7: An install writes a valid entry with its dirty and reference bits clear. If a valid entry already holds the same page number, that entry is replaced in place, so no page number is ever held twice.
- R8: An install of a new page number goes into the lowest-indexed invalid entry, if there is one.
- R9: The reference bit of an entry is set by every lookup that matches it, whether or not the access is permitted. When all entries are valid, a new page number replaces the lowest-indexed entry whose reference bit is clear.
- R10: When all entries are valid and all reference bits are set, an install of a new page number clears every reference bit and replaces entry 0.
- R11: The dirty bit of an entry is set by a permitted write hit. A read, a fetch or a faulting write leaves it unchanged.
- R12: One cycle after an install that overwrites a valid entry, ev_valid=1 and ev_vpn and ev_dirty give that entry's page number and dirty bit. After any other cycle, ev_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_access | input | 2 | Access kind (R4 encoding) |
| lk_hit | output | 1 | Permitted match for the previous request |
| lk_miss | output | 1 | No valid match for the previous request |
| lk_fault | output | 1 | Match whose rights deny the access |
| lk_paddr | output | PA_W | Translated physical address on a hit, otherwise 0 |
| ins_valid | input | 1 | Install request this cycle |
| ins_vpn | input | VA_W-12 | Virtual page number to install |
| ins_ppn | input | PA_W-12 | Physical page number to install |
| ins_rights | input | 2 | Rights of the new entry (R4 encoding) |
| ev_valid | output | 1 | The previous install overwrote a live entry |
| ev_vpn | output | VA_W-12 | Page number of the overwritten entry |
| ev_dirty | output | 1 | Dirty bit of the overwritten entry |

## Verification
The bench builds the block with ENTRIES=4 and the default 32-bit address widths. With four entries, every combination of the four rights codes and the four access codes can be swept at three page offsets. The small size also makes each replacement case reachable within a few installs:
- a victim chosen because an entry is invalid,
- a victim chosen because its reference bit is clear,
- the clear-all case that falls back to entry 0,
- an in-place replacement of a page number already held.

Because entries are evicted in a known order, dirty and reference state can be read back through the eviction port.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    // Access kinds presented with a lookup
    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    // Rights codes held per entry
    localparam logic [1:0] RGT_RO   = 2'b00;
    localparam logic [1:0] RGT_RW   = 2'b01;
    localparam logic [1:0] RGT_EXEC = 2'b10;

    function automatic logic access_ok(input logic [1:0] rights, input logic [1:0] acc);
        logic ok;
        case (rights)
            RGT_RO:   ok = (acc == ACC_READ);
            RGT_RW:   ok = (acc == ACC_READ) || (acc == ACC_WRITE);
            RGT_EXEC: ok = (acc == ACC_READ) || (acc == ACC_FETCH);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_first_one.sv
module tlb_first_one #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [VPN_W-1:0]               key,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  tags,
    output logic                           found,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    tlb_first_one #(.N(ENTRIES)) enc_i (
        .vec   (match),
        .found (found),
        .idx   (idx)
    );

    // Installs replace an existing page in place, so at most one tag may match
    assert_cam_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] refd,
    output logic [IDX_W-1:0]   victim,
    output logic               clear_all
);
    logic             free_found, cold_found;
    logic [IDX_W-1:0] free_idx, cold_idx;

    tlb_first_one #(.N(ENTRIES)) free_i (
        .vec   (~valid),
        .found (free_found),
        .idx   (free_idx)
    );

    tlb_first_one #(.N(ENTRIES)) cold_i (
        .vec   (~refd),
        .found (cold_found),
        .idx   (cold_idx)
    );

    always_comb begin
        clear_all = 1'b0;
        if (free_found) begin
            victim = free_idx;
        end else if (cold_found) begin
            victim = cold_idx;
        end else begin
            victim    = '0;
            clear_all = 1'b1;
        end
    end

    assert_victim_free_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~valid)) |-> !valid[victim]);

    assert_victim_cold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid) && !(&refd)) |-> (!refd[victim] && !clear_all));

    assert_victim_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |-> ((victim == '0) && (&valid) && (&refd)));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12,
    localparam int VPN_W  = VA_W - PAGE_W,
    localparam int PPN_W  = PA_W - PAGE_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_access,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [1:0]       ins_rights,
    output logic             ev_valid,
    output logic [VPN_W-1:0] ev_vpn,
    output logic             ev_dirty
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            refd;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0][1:0]       rights;
        logic                          hit;
        logic                          miss;
        logic                          fault;
        logic [PA_W-1:0]               paddr;
        logic                          ev_valid;
        logic [VPN_W-1:0]              ev_vpn;
        logic                          ev_dirty;
    } state_t;

    state_t state_d, state_q;

    logic             lk_found, ins_found, vic_clear;
    logic [IDX_W-1:0] lk_idx, ins_idx, vic_idx, slot;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) lk_cam_i (
        .clk   (clk),
        .rst_n (rst_n),
        .key   (lk_vaddr[VA_W-1:PAGE_W]),
        .valid (state_q.valid),
        .tags  (state_q.vpn),
        .found (lk_found),
        .idx   (lk_idx)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) ins_cam_i (
        .clk   (clk),
        .rst_n (rst_n),
        .key   (ins_vpn),
        .valid (state_q.valid),
        .tags  (state_q.vpn),
        .found (ins_found),
        .idx   (ins_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (state_q.valid),
        .refd      (state_q.refd),
        .victim    (vic_idx),
        .clear_all (vic_clear)
    );

    always_comb begin
        state_d          = state_q;
        state_d.hit      = 1'b0;
        state_d.miss     = 1'b0;
        state_d.fault    = 1'b0;
        state_d.paddr    = '0;
        state_d.ev_valid = 1'b0;
        state_d.ev_vpn   = '0;
        state_d.ev_dirty = 1'b0;
        slot             = ins_found ? ins_idx : vic_idx;

        // Reference wrap happens before this cycle's lookup marks its entry
        if (ins_valid && !ins_found && vic_clear) begin
            state_d.refd = '0;
        end

        if (lk_valid) begin
            if (lk_found) begin
                state_d.refd[lk_idx] = 1'b1;
                if (access_ok(state_q.rights[lk_idx], lk_access)) begin
                    state_d.hit   = 1'b1;
                    state_d.paddr = {state_q.ppn[lk_idx], lk_vaddr[PAGE_W-1:0]};
                    if (lk_access == ACC_WRITE) begin
                        state_d.dirty[lk_idx] = 1'b1;
                    end
                end else begin
                    state_d.fault = 1'b1;
                end
            end else begin
                state_d.miss = 1'b1;
            end
        end

        if (ins_valid) begin
            state_d.ev_valid     = state_q.valid[slot];
            state_d.ev_vpn       = state_q.vpn[slot];
            state_d.ev_dirty     = state_d.dirty[slot];
            state_d.valid[slot]  = 1'b1;
            state_d.vpn[slot]    = ins_vpn;
            state_d.ppn[slot]    = ins_ppn;
            state_d.rights[slot] = ins_rights;
            state_d.dirty[slot]  = 1'b0;
            state_d.refd[slot]   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lk_hit   = state_q.hit;
    assign lk_miss  = state_q.miss;
    assign lk_fault = state_q.fault;
    assign lk_paddr = state_q.paddr;
    assign ev_valid = state_q.ev_valid;
    assign ev_vpn   = state_q.ev_vpn;
    assign ev_dirty = state_q.ev_dirty;

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss, lk_fault}));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(lk_hit || lk_miss || lk_fault || (lk_paddr != '0)));

    assert_miss_no_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_found) |=> (lk_miss && !lk_fault));

    assert_offset_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_found) |=>
            (!lk_hit || (lk_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0]))));

    assert_dirty_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_found && !ins_valid && (lk_access == ACC_WRITE)) |=>
            (!lk_hit || state_q.dirty[$past(lk_idx)]));

    assert_evict_needs_install_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> !ev_valid);
endmodule

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;
    localparam int N     = 4;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [31:0]      lk_vaddr = '0;
    logic [1:0]       lk_access = '0;
    logic             lk_hit, lk_miss, lk_fault;
    logic [31:0]      lk_paddr;
    logic             ins_valid = 1'b0;
    logic [VPN_W-1:0] ins_vpn = '0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [1:0]       ins_rights = '0;
    logic             ev_valid, ev_dirty;
    logic [VPN_W-1:0] ev_vpn;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    soft_tlb #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_access(lk_access),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_rights(ins_rights),
        .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_dirty(ev_dirty)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Rights/access table written out from R4
    function automatic bit allowed(input int r, input int a);
        return (a == 0 && r != 3) || (a == 1 && r == 1) || (a == 2 && r == 2);
    endfunction

    task automatic lookup(input logic [31:0] va, input logic [1:0] acc);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_access = acc;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic install(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [1:0] r);
        @(negedge clk);
        ins_valid = 1'b1; ins_vpn = v; ins_ppn = p; ins_rights = r;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic expect_lk(input string req, input bit h, input bit m, input bit f, input logic [31:0] pa);
        chk(req, "hit", lk_hit, h);
        chk(req, "miss", lk_miss, m);
        chk(req, "fault", lk_fault, f);
        chk(req, "paddr", lk_paddr, pa);
    endtask

    task automatic expect_ev(input string req, input bit v, input logic [VPN_W-1:0] vp, input bit d);
        chk(req, "ev_valid", ev_valid, v);
        if (v) begin
            chk(req, "ev_vpn", ev_vpn, vp);
            chk(req, "ev_dirty", ev_dirty, d);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [3];
        offs[0] = 12'h000; offs[1] = 12'hABC; offs[2] = 12'hFFF;

        // R1: state held in reset
        repeat (3) @(negedge clk);
        expect_lk("R1", 0, 0, 0, 0);
        chk("R1", "ev_valid", ev_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_lk("R6", 0, 0, 0, 0);

        // R1/R3: empty table always misses
        for (int v = 0; v < 8; v++) begin
            lookup({20'(v + 'h10), 12'h123}, 2'(v % 4));
            expect_lk("R1 R3", 0, 1, 0, 0);
        end

        // R8: fill free entries in order, no eviction; rights i on entry i
        for (int i = 0; i < N; i++) begin
            install(20'('h10 + i), 20'('h200 + i), 2'(i));
            expect_ev("R8 R12", 0, 0, 0);
        end

        // R2/R4: sweep every rights and access code at several offsets
        for (int i = 0; i < N; i++) begin
            for (int a = 0; a < 4; a++) begin
                for (int o = 0; o < 3; o++) begin
                    lookup({20'('h10 + i), offs[o]}, 2'(a));
                    if (allowed(i, a))
                        expect_lk("R2 R4", 1, 0, 0, {20'('h200 + i), offs[o]});
                    else
                        expect_lk("R4", 0, 0, 1, 0);
                end
            end
        end

        // R6: idle cycle quiet after activity
        @(negedge clk);
        expect_lk("R6", 0, 0, 0, 0);

        // R5: unmapped page with reserved access reports only a miss
        lookup({20'h00099, 12'h010}, 2'b11);
        expect_lk("R5", 0, 1, 0, 0);
        lookup({20'h00014, 12'h010}, 2'b00);
        expect_lk("R5 R3", 0, 1, 0, 0);

        // R10: all valid, all referenced -> entry 0 (vpn 0x10, never written)
        install(20'h00020, 20'h00300, 2'b01);
        expect_ev("R10 R12", 1, 20'h00010, 0);

        // R9: reference entry 0 again; entry 1 (written, RW) is first cold
        lookup({20'h00020, 12'h004}, 2'b00);
        expect_lk("R9 R7", 1, 0, 0, {20'h00300, 12'h004});
        install(20'h00021, 20'h00301, 2'b00);
        expect_ev("R9 R11", 1, 20'h00011, 1);

        // R9: a faulting lookup still marks its entry; only entry 2 stays cold
        lookup({20'h00021, 12'h000}, 2'b00);
        expect_lk("R9", 1, 0, 0, {20'h00301, 12'h000});
        lookup({20'h00013, 12'h000}, 2'b00);
        expect_lk("R9 R4", 0, 0, 1, 0);
        install(20'h00022, 20'h00302, 2'b01);
        expect_ev("R9 R11", 1, 20'h00012, 0);

        // R7: same page reinstalled in place, with its clean state reported
        install(20'h00022, 20'h00400, 2'b01);
        expect_ev("R7 R12", 1, 20'h00022, 0);
        lookup({20'h00022, 12'h777}, 2'b01);
        expect_lk("R7 R11", 1, 0, 0, {20'h00400, 12'h777});
        install(20'h00022, 20'h00401, 2'b00);
        expect_ev("R11 R12", 1, 20'h00022, 1);
        lookup({20'h00022, 12'h777}, 2'b01);
        expect_lk("R7 R4", 0, 0, 1, 0);
        lookup({20'h00022, 12'h001}, 2'b00);
        expect_lk("R7", 1, 0, 0, {20'h00401, 12'h001});

        // Other entries untouched by in-place replacement
        lookup({20'h00020, 12'hFFF}, 2'b01);
        expect_lk("R7", 1, 0, 0, {20'h00300, 12'hFFF});
        lookup({20'h00021, 12'h800}, 2'b01);
        expect_lk("R4", 0, 0, 1, 0);

        // R12: no install -> no eviction report
        @(negedge clk);
        chk("R12", "ev_valid idle", ev_valid, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule